// File: doc/BRIEF.md
# Dual-Port Write Arbiter and Bank Selector

This block coordinates two two-wire host ports that share a pair of 128-byte memory banks. Each port has its own slave controller. Each controller reports three things to this block: whether a command is in progress, a pulse when bit D0 of the first data byte of a write arrives, and a pulse when that port's write cycle has finished. From these reports the block decides which port may answer its bus, which port owns the single write path, and which bank each port addresses.

In dual-port operation, port 0 addresses bank 0 and port 1 addresses bank 1. Both ports may read at once. Write ownership goes to the port whose D0 pulse arrives first. The losing port is then refused for every access until the owner's write cycle ends. In single-port operation only port 0 is served, and a bank-select input picks its bank.

The block also drives the select and enable for a monitor pass-through that mirrors one port's bus. A write-permit input can block all writes. At board level that input should default low, so that writes are blocked unless it is driven high.

Top module: `dpw_arbiter`

## Requirements
- R1: During and after reset, no port owns the write path, both ports are served, the configuration is dual-port with bank select 0, and mon_sel_o is 0. A reset asserted while a port owns the write path clears that ownership.
- R2: In dual-port mode (mode_single_i=0) with no owner, both p_serve_o bits are 1. Port 0 addresses bank 0 and port 1 addresses bank 1: p_bank_o[0]=0 and p_bank_o[1]=1.
- R3: With no owner and wr_allow_i=1, a D0 pulse on a served port makes that port's p_wgrant_o bit 1 from the next clock edge.
- R4: If D0 pulses arrive on both ports in the same cycle, port 0 takes ownership.
- R5: While one port owns the write path, the other port's p_serve_o bit is 0 and its D0 pulses are ignored. A write-done pulse from the non-owner is ignored. A write-done pulse from the owner releases ownership at the next clock edge.
- R6: In single-port mode (mode_single_i=1), p_serve_o[1] is 0 and port 1's D0 pulses are ignored. Port 0 addresses the bank given by bank_sel_i (0 selects bank 0, 1 selects bank 1), and p_bank_o[1] reads 0.
- R7: mon_oe_o follows mon_en_i in the same cycle; 0 means the monitor outputs are released. mon_sel_o is the latched bank select in dual-port mode and 0 (port 0) in single-port mode.
- R8: With wr_allow_i=0, no D0 pulse grants ownership. Dropping wr_allow_i while a port owns the write path does not end that port's ownership.
- R9: mode_single_i and bank_sel_i are sampled only at clock edges where every served port has p_busy_i low. In single-port mode only port 0 counts as served. At other edges, changes on these inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_single_i | input | 1 | 0 selects dual-port, 1 selects single-port |
| bank_sel_i | input | 1 | Bank for port 0 in single-port mode; monitor port in dual-port mode |
| mon_en_i | input | 1 | Monitor pass-through enable |
| wr_allow_i | input | 1 | 1 permits writes, 0 blocks all writes |
| p_busy_i | input | 2 | Per port: command in progress |
| p_d0_i | input | 2 | Per port: pulse when D0 of the first write data byte arrives |
| p_wdone_i | input | 2 | Per port: pulse when the write cycle completes |
| p_serve_o | output | 2 | Per port: controller may acknowledge and respond |
| p_wgrant_o | output | 2 | Per port: owns the write path |
| p_bank_o | output | 2 | Per port: bank index (bit i for port i) |
| mon_sel_o | output | 1 | Monitor mux select: 0 port 0, 1 port 1 |
| mon_oe_o | output | 1 | Monitor output enable; 0 releases the outputs |

## Verification
The hardest situation to reach is two D0 pulses landing in the same clock cycle while both ports are mid-command. The stimulus table raises both busy bits and then both D0 bits in one vector, which forces the tie and checks that port 0 wins. The same approach sets up a write-done pulse from the losing port during another port's ownership, and a mode change requested while port 0 is busy. In both cases the bench checks that the request has no effect until the ports are idle.

// File: rtl/dpw_pkg.sv
package dpw_pkg;
    localparam int NPORT  = 2;
    localparam int BANK_W = 1;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_P0   = 2'd1,
        OWN_P1   = 2'd2
    } owner_e;

    typedef struct packed {
        logic              single;
        logic [BANK_W-1:0] bank;
    } cfg_t;

    function automatic owner_e owner_of(input int port);
        return (port == 0) ? OWN_P0 : OWN_P1;
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(input cfg_t c, input int port);
        if (c.single)
            return (port == 0) ? c.bank : '0;
        return BANK_W'(port);
    endfunction
endpackage

// File: rtl/dpw_cfg_latch.sv
module dpw_cfg_latch
    import dpw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             single_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [NPORT-1:0] busy_i,
    output cfg_t             cfg_o
);
    logic idle;

    assign idle = !busy_i[0] && (cfg_o.single || !busy_i[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= '0;
        end else if (idle) begin
            cfg_o.single <= single_i;
            cfg_o.bank   <= bank_i;
        end
    end

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !idle |=> $stable(cfg_o));
endmodule

// File: rtl/dpw_write_owner.sv
module dpw_write_owner
    import dpw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             single_i,
    input  logic             wr_allow_i,
    input  logic [NPORT-1:0] d0_i,
    input  logic [NPORT-1:0] wdone_i,
    output owner_e           owner_o
);
    owner_e owner_n;
    logic   p1_live;

    assign p1_live = !single_i;

    always_comb begin
        owner_n = owner_o;
        unique case (owner_o)
            OWN_NONE: begin
                if (wr_allow_i) begin
                    if (d0_i[0])
                        owner_n = OWN_P0;
                    else if (d0_i[1] && p1_live)
                        owner_n = OWN_P1;
                end
            end
            OWN_P0:  if (wdone_i[0]) owner_n = OWN_NONE;
            OWN_P1:  if (wdone_i[1]) owner_n = OWN_NONE;
            default: owner_n = OWN_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) owner_o <= OWN_NONE;
        else     owner_o <= owner_n;
    end

    assert_no_steal_p0_R5: assert property (@(posedge clk) disable iff (rst)
        (owner_o == OWN_P0) |=> (owner_o != OWN_P1));
    assert_no_steal_p1_R5: assert property (@(posedge clk) disable iff (rst)
        (owner_o == OWN_P1) |=> (owner_o != OWN_P0));
    assert_protect_R8: assert property (@(posedge clk) disable iff (rst)
        (!wr_allow_i && owner_o == OWN_NONE) |=> (owner_o == OWN_NONE));
    assert_tie_p0_R4: assert property (@(posedge clk) disable iff (rst)
        (owner_o == OWN_NONE && wr_allow_i && d0_i[0]) |=> (owner_o == OWN_P0));
    assert_single_p1_R6: assert property (@(posedge clk) disable iff (rst)
        (single_i && owner_o == OWN_NONE) |=> (owner_o != OWN_P1));
endmodule

// File: rtl/dpw_route.sv
module dpw_route
    import dpw_pkg::*;
(
    input  cfg_t                    cfg_i,
    input  owner_e                  owner_i,
    input  logic                    mon_en_i,
    output logic [NPORT-1:0]        serve_o,
    output logic [NPORT-1:0]        wgrant_o,
    output logic [NPORT*BANK_W-1:0] bank_o,
    output logic                    mon_sel_o,
    output logic                    mon_oe_o
);
    for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
        logic active;
        logic locked;
        assign active  = (gi == 0) ? 1'b1 : !cfg_i.single;
        assign locked  = (owner_i != OWN_NONE) && (owner_i != owner_of(gi));
        assign serve_o[gi]  = active && !locked;
        assign wgrant_o[gi] = (owner_i == owner_of(gi));
        assign bank_o[gi*BANK_W +: BANK_W] = bank_of(cfg_i, gi);
    end

    assign mon_sel_o = cfg_i.single ? 1'b0 : cfg_i.bank[0];
    assign mon_oe_o  = mon_en_i;
endmodule

// File: rtl/dpw_arbiter.sv
module dpw_arbiter
    import dpw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_single_i,
    input  logic       bank_sel_i,
    input  logic       mon_en_i,
    input  logic       wr_allow_i,
    input  logic [1:0] p_busy_i,
    input  logic [1:0] p_d0_i,
    input  logic [1:0] p_wdone_i,
    output logic [1:0] p_serve_o,
    output logic [1:0] p_wgrant_o,
    output logic [1:0] p_bank_o,
    output logic       mon_sel_o,
    output logic       mon_oe_o
);
    cfg_t   cfg;
    owner_e owner;

    dpw_cfg_latch u_cfg (
        .clk      (clk),
        .rst      (rst),
        .single_i (mode_single_i),
        .bank_i   (bank_sel_i),
        .busy_i   (p_busy_i),
        .cfg_o    (cfg)
    );

    dpw_write_owner u_own (
        .clk        (clk),
        .rst        (rst),
        .single_i   (cfg.single),
        .wr_allow_i (wr_allow_i),
        .d0_i       (p_d0_i),
        .wdone_i    (p_wdone_i),
        .owner_o    (owner)
    );

    dpw_route u_route (
        .cfg_i     (cfg),
        .owner_i   (owner),
        .mon_en_i  (mon_en_i),
        .serve_o   (p_serve_o),
        .wgrant_o  (p_wgrant_o),
        .bank_o    (p_bank_o),
        .mon_sel_o (mon_sel_o),
        .mon_oe_o  (mon_oe_o)
    );

    assert_lock_p1_R5: assert property (@(posedge clk) disable iff (rst)
        p_wgrant_o[0] |-> !p_serve_o[1]);
    assert_lock_p0_R5: assert property (@(posedge clk) disable iff (rst)
        p_wgrant_o[1] |-> !p_serve_o[0]);
    assert_owner_served_R3: assert property (@(posedge clk) disable iff (rst)
        (p_wgrant_o & ~p_serve_o) == 2'b00);
    assert_release_R5: assert property (@(posedge clk) disable iff (rst)
        (p_wgrant_o[0] && p_wdone_i[0]) |=> !p_wgrant_o[0]);
    assert_single_mon_R7: assert property (@(posedge clk) disable iff (rst)
        (!p_serve_o[1] && !p_wgrant_o[0] && $countones(p_wgrant_o) == 0) |-> !mon_sel_o);
endmodule

// File: tb/dpw_arbiter_tb.sv
module dpw_arbiter_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       mode_single_i, bank_sel_i, mon_en_i, wr_allow_i;
    logic [1:0] p_busy_i, p_d0_i, p_wdone_i;
    logic [1:0] p_serve_o, p_wgrant_o, p_bank_o;
    logic       mon_sel_o, mon_oe_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    dpw_arbiter u_dut (
        .clk (clk), .rst (rst),
        .mode_single_i (mode_single_i), .bank_sel_i (bank_sel_i),
        .mon_en_i (mon_en_i), .wr_allow_i (wr_allow_i),
        .p_busy_i (p_busy_i), .p_d0_i (p_d0_i), .p_wdone_i (p_wdone_i),
        .p_serve_o (p_serve_o), .p_wgrant_o (p_wgrant_o), .p_bank_o (p_bank_o),
        .mon_sel_o (mon_sel_o), .mon_oe_o (mon_oe_o)
    );

    // inputs: single bank mon allow busy[1:0] d0[1:0] wdone[1:0]
    // expect: serve[1:0] wgrant[1:0] bank[1:0] mon_sel mon_oe
    localparam int NV = 18;
    localparam logic [17:0] VEC [NV] = '{
        {10'b0_0_0_1_00_00_00, 8'b11_00_10_0_0}, // R2 idle dual
        {10'b0_1_1_1_11_00_00, 8'b11_00_10_0_1}, // R9 bank change held while busy
        {10'b0_1_1_1_00_00_00, 8'b11_00_10_1_1}, // R7 bank applied, monitor port 1
        {10'b0_1_1_1_11_10_00, 8'b10_10_10_1_1}, // R3 port 1 first
        {10'b0_1_1_1_11_01_00, 8'b10_10_10_1_1}, // R5 late port 0 ignored
        {10'b0_1_1_0_11_00_00, 8'b10_10_10_1_1}, // R8 protect keeps owner
        {10'b0_1_1_1_01_00_10, 8'b11_00_10_1_1}, // R5 owner releases
        {10'b0_1_1_1_11_11_00, 8'b01_01_10_1_1}, // R4 tie to port 0
        {10'b0_1_1_1_11_00_10, 8'b01_01_10_1_1}, // R5 non-owner done ignored
        {10'b0_1_1_1_00_00_01, 8'b11_00_10_1_1}, // R5 release
        {10'b0_1_1_0_00_01_00, 8'b11_00_10_1_1}, // R8 blocked write
        {10'b1_1_1_1_00_00_00, 8'b01_00_01_0_1}, // R6 single, bank 1
        {10'b1_1_1_1_10_10_00, 8'b01_00_01_0_1}, // R6 port 1 ignored
        {10'b1_0_1_1_01_00_00, 8'b01_00_01_0_1}, // R9 bank held while busy
        {10'b0_0_1_1_01_00_00, 8'b01_00_01_0_1}, // R9 mode held while busy
        {10'b0_0_0_1_00_00_00, 8'b11_00_10_0_0}, // R9 applied when idle
        {10'b0_0_0_1_01_01_00, 8'b01_01_10_0_0}, // R3 port 0 owns
        {10'b0_0_0_1_01_00_01, 8'b11_00_10_0_0}  // R5 release
    };
    localparam int TAG [NV] = '{2,9,7,3,5,8,5,4,5,5,8,6,6,9,9,9,3,5};

    function automatic logic [7:0] outs();
        return {p_serve_o, p_wgrant_o, p_bank_o, mon_sel_o, mon_oe_o};
    endfunction

    task automatic apply(input logic [9:0] v);
        {mode_single_i, bank_sel_i, mon_en_i, wr_allow_i, p_busy_i, p_d0_i, p_wdone_i} = v;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
                finish_run();
            end
        end
    end

    initial begin
        rst = 1'b1;
        apply(10'b0_1_1_0_11_11_00);
        repeat (3) @(negedge clk);
        // R1 reset state while reset held
        check("R1 reset", outs(), 8'b11_00_10_0_1);
        rst = 1'b0;
        apply(10'b0_0_0_1_00_00_00);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][17:8]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", TAG[i], i), outs(), VEC[i][7:0]);
        end

        // R1 reset clears ownership
        apply(10'b0_0_0_1_11_10_00);
        @(negedge clk);
        check("R3 port 1 owns before reset", outs(), 8'b10_10_10_0_0);
        rst = 1'b1;
        apply(10'b0_0_0_1_11_00_00);
        @(negedge clk);
        check("R1 reset mid-ownership", outs(), 8'b11_00_10_0_0);
        rst = 1'b0;

        // R6 single mode: port 0 bank follows bank select 0
        apply(10'b1_0_0_1_00_00_00);
        @(negedge clk);
        check("R6 single bank 0", outs(), 8'b01_00_00_0_0);
        // R6 port 0 write in single mode
        apply(10'b1_0_0_1_01_01_00);
        @(negedge clk);
        check("R6 single port 0 owns", outs(), 8'b01_01_00_0_0);
        apply(10'b1_0_0_1_00_00_01);
        @(negedge clk);
        check("R5 single release", outs(), 8'b01_00_00_0_0);

        finish_run();
    end
endmodule